// File: doc/BRIEF.md
# Adaptive Slip Control Queue

This block governs how far a prefetch engine may run ahead of the access engine that consumes its data. Both engines walk the same loop; the prefetch side presents one token per iteration and the access side takes one token per iteration. The number of tokens in flight is the slip. The prefetch side is held back once the slip reaches the current limit. The access side is held back while no token is outstanding.

The limit is not fixed. The block counts the prefetches reported as late, meaning the data landed after the matching load had already gone out. It also counts the prefetches reported as useful, meaning the data landed before the load. After every fixed window of accepted gets, it compares the two counts and moves the limit up or down by one. No change is made while the prefetch buffer reports itself full. The limit stays between one and a configured maximum.

Top module: `slip_ctrl_queue`

## Requirements
- R1: After reset the slip limit is 4 and the occupancy is 0, and the late and useful tallies start at zero.
- R2: `putAck` is high in a cycle exactly when `putReq` is high and the occupancy is below the slip limit. An accepted put raises the occupancy by one.
- R3: `getAck` is high in a cycle exactly when `getReq` is high and the occupancy is above zero. An accepted get lowers the occupancy by one.
- R4: When a put and a get are both accepted in the same cycle, the occupancy is unchanged.
- R5: An evaluation takes place on the clock edge that accepts the 64th get of a window. The new limit is visible in the following cycle, and the limit never changes at any other time.
- R6: If `pfBufFull` is high in the evaluation cycle, the limit is left unchanged.
- R7: Otherwise, if twice the late count exceeds the useful count, the limit rises by one. Events reported in the evaluation cycle itself are included in the counts.
- R8: Otherwise the limit falls by one; equality of twice-late and useful counts as a fall.
- R9: The limit stays within 1 to 16: a rise at 16 and a fall at 1 leave it unchanged.
- R10: Both tallies restart from zero after each evaluation, so one window's events never affect the next decision.
- R11: Lowering the limit discards no token. Puts are refused until the occupancy is below the new limit, and every held token can still be drained by gets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| putReq | input | 1 | Prefetch side offers one iteration token |
| putAck | output | 1 | Token accepted this cycle (combinational) |
| getReq | input | 1 | Access side asks for one iteration token |
| getAck | output | 1 | Token handed over this cycle (combinational) |
| lateEvt | input | 1 | One prefetch was late this cycle |
| usefulEvt | input | 1 | One prefetch was useful this cycle |
| pfBufFull | input | 1 | Prefetch buffer is full |
| slipLimit | output | 5 | Current allowed slip |
| occupancy | output | 5 | Tokens currently outstanding |

## Verification
The bench pushes the occupancy against the limit and against zero, with simultaneous put and get on each edge. A design with an off-by-one gate would overfill or underflow at those points. It runs full windows whose late and useful mixes sit on each side of the decision, including the exact tie: a design using greater-or-equal would raise the limit on the tie instead of lowering it. Back-to-back windows of opposite character expose tallies that fail to restart, and repeated windows at both clamps expose a limit that wraps. The bench also lowers the limit while the queue is full. A design that dropped tokens there, or still accepted puts, would show the wrong occupancy.

// File: rtl/slip_pkg.sv
package slip_pkg;

  // Strobes issued by the control each cycle to the datapath.
  typedef struct packed {
    logic putAcc;
    logic getAcc;
    logic evalNow;
    logic incLimit;
    logic decLimit;
  } slipStrobe_t;

endpackage

// File: rtl/slip_dpath.sv
module slip_dpath
  import slip_pkg::*;
#(
  parameter int MAX_LIMIT  = 16,
  parameter int INIT_LIMIT = 4,
  parameter int WINDOW     = 64,
  localparam int LIM_W     = $clog2(MAX_LIMIT + 1),
  localparam int WIN_W     = $clog2(WINDOW),
  localparam int EVT_W     = WIN_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  slipStrobe_t      st,
  input  logic             lateEvt,
  input  logic             usefulEvt,
  input  logic             pfBufFull,
  output logic [LIM_W-1:0] occ,
  output logic [LIM_W-1:0] limit,
  output logic             winLast,
  output logic [EVT_W-1:0] lateNext,
  output logic [EVT_W-1:0] usefulNext
);

  logic [LIM_W-1:0] occQ;
  logic [LIM_W-1:0] limitQ;
  logic [WIN_W-1:0] getCntQ;
  logic [EVT_W-1:0] lateQ;
  logic [EVT_W-1:0] usefulQ;

  // Saturating event tally, so a burst of events never wraps.
  function automatic logic [EVT_W-1:0] satBump(input logic [EVT_W-1:0] cnt, input logic hit);
    if (hit && (cnt != {EVT_W{1'b1}})) return cnt + EVT_W'(1);
    return cnt;
  endfunction

  assign lateNext   = satBump(lateQ, lateEvt);
  assign usefulNext = satBump(usefulQ, usefulEvt);
  assign winLast    = (getCntQ == WIN_W'(WINDOW - 1));
  assign occ        = occQ;
  assign limit      = limitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occQ    <= '0;
      limitQ  <= LIM_W'(INIT_LIMIT);
      getCntQ <= '0;
      lateQ   <= '0;
      usefulQ <= '0;
    end else begin
      case ({st.putAcc, st.getAcc})
        2'b10:   occQ <= occQ + LIM_W'(1);
        2'b01:   occQ <= occQ - LIM_W'(1);
        default: occQ <= occQ;
      endcase

      if (st.getAcc) getCntQ <= winLast ? '0 : getCntQ + WIN_W'(1);

      if (st.evalNow) begin
        lateQ   <= '0;
        usefulQ <= '0;
      end else begin
        lateQ   <= lateNext;
        usefulQ <= usefulNext;
      end

      if (st.incLimit)      limitQ <= limitQ + LIM_W'(1);
      else if (st.decLimit) limitQ <= limitQ - LIM_W'(1);
    end
  end

  p_limit_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (limitQ >= LIM_W'(1)) && (limitQ <= LIM_W'(MAX_LIMIT)));

  p_limit_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.evalNow |=> $stable(limitQ));

  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.evalNow && pfBufFull) |=> $stable(limitQ));

  p_step_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.evalNow |=> (limitQ == $past(limitQ)) ||
                   (limitQ == $past(limitQ) + LIM_W'(1)) ||
                   (limitQ == $past(limitQ) - LIM_W'(1)));

  p_occ_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    occQ <= limitQ);

endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl
  import slip_pkg::*;
#(
  parameter int MAX_LIMIT = 16,
  parameter int WINDOW    = 64,
  localparam int LIM_W    = $clog2(MAX_LIMIT + 1),
  localparam int WIN_W    = $clog2(WINDOW),
  localparam int EVT_W    = WIN_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             putReq,
  input  logic             getReq,
  input  logic             pfBufFull,
  input  logic [LIM_W-1:0] occ,
  input  logic [LIM_W-1:0] limit,
  input  logic             winLast,
  input  logic [EVT_W-1:0] lateNext,
  input  logic [EVT_W-1:0] usefulNext,
  output slipStrobe_t      st,
  output logic             putAck,
  output logic             getAck
);

  logic wantMore;
  logic judge;

  // Twice the late count against the useful count, one bit wider.
  assign wantMore = ({lateNext, 1'b0} > {1'b0, usefulNext});

  always_comb begin
    st.putAcc   = putReq && (occ < limit);
    st.getAcc   = getReq && (occ != '0);
    st.evalNow  = st.getAcc && winLast;
    judge       = st.evalNow && !pfBufFull;
    st.incLimit = judge &&  wantMore && (limit != LIM_W'(MAX_LIMIT));
    st.decLimit = judge && !wantMore && (limit != LIM_W'(1));
  end

  assign putAck = st.putAcc;
  assign getAck = st.getAcc;

  p_put_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    putAck |-> (occ < limit));

  p_get_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    getAck |-> (occ != '0));

  p_one_way_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(st.incLimit && st.decLimit));

endmodule

// File: rtl/slip_ctrl_queue.sv
module slip_ctrl_queue
  import slip_pkg::*;
#(
  parameter int MAX_LIMIT  = 16,
  parameter int INIT_LIMIT = 4,
  parameter int WINDOW     = 64,
  localparam int LIM_W     = $clog2(MAX_LIMIT + 1),
  localparam int WIN_W     = $clog2(WINDOW),
  localparam int EVT_W     = WIN_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             putReq,
  output logic             putAck,
  input  logic             getReq,
  output logic             getAck,
  input  logic             lateEvt,
  input  logic             usefulEvt,
  input  logic             pfBufFull,
  output logic [LIM_W-1:0] slipLimit,
  output logic [LIM_W-1:0] occupancy
);

  slipStrobe_t      st;
  logic             winLast;
  logic [EVT_W-1:0] lateNext;
  logic [EVT_W-1:0] usefulNext;

  slip_ctrl #(.MAX_LIMIT(MAX_LIMIT), .WINDOW(WINDOW)) uCtrl (
    .clk(clk), .rstN(rstN), .putReq(putReq), .getReq(getReq),
    .pfBufFull(pfBufFull), .occ(occupancy), .limit(slipLimit),
    .winLast(winLast), .lateNext(lateNext), .usefulNext(usefulNext),
    .st(st), .putAck(putAck), .getAck(getAck)
  );

  slip_dpath #(.MAX_LIMIT(MAX_LIMIT), .INIT_LIMIT(INIT_LIMIT), .WINDOW(WINDOW)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .lateEvt(lateEvt),
    .usefulEvt(usefulEvt), .pfBufFull(pfBufFull), .occ(occupancy),
    .limit(slipLimit), .winLast(winLast), .lateNext(lateNext),
    .usefulNext(usefulNext)
  );

endmodule

// File: tb/sim_slip_ctrl_queue.sv
`timescale 1ns/100ps
module sim_slip_ctrl_queue;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic putReq = 1'b0, getReq = 1'b0, lateEvt = 1'b0, usefulEvt = 1'b0, pfBufFull = 1'b0;
  logic putAck, getAck;
  logic [4:0] slipLimit, occupancy;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  slip_ctrl_queue u0 (
    .clk(clk), .rstN(rstN), .putReq(putReq), .putAck(putAck),
    .getReq(getReq), .getAck(getAck), .lateEvt(lateEvt),
    .usefulEvt(usefulEvt), .pfBufFull(pfBufFull),
    .slipLimit(slipLimit), .occupancy(occupancy)
  );

  // {put, get, late, useful, full, expPutAck, expGetAck, expOcc[4:0]}, limit 4 throughout
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    {5'b10000, 2'b10, 5'd1},
    {5'b10100, 2'b10, 5'd2},
    {5'b11000, 2'b11, 5'd2},
    {5'b10010, 2'b10, 5'd3},
    {5'b10000, 2'b10, 5'd4},
    {5'b10000, 2'b00, 5'd4},
    {5'b11100, 2'b01, 5'd3},
    {5'b01000, 2'b01, 5'd2},
    {5'b01010, 2'b01, 5'd1},
    {5'b01000, 2'b01, 5'd0},
    {5'b01000, 2'b00, 5'd0},
    {5'b11001, 2'b10, 5'd1},
    {5'b01000, 2'b01, 5'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, sample acks 1 ns later, sample state 1 ns after the rising edge.
  task automatic step(input logic p, g, l, u, f, output logic pa, ga);
    @(negedge clk);
    putReq = p; getReq = g; lateEvt = l; usefulEvt = u; pfBufFull = f;
    #1;
    pa = putAck; ga = getAck;
    @(posedge clk);
    #1;
    putReq = 1'b0; getReq = 1'b0; lateEvt = 1'b0; usefulEvt = 1'b0; pfBufFull = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
  endtask

  // n put/get pairs; lateMode 0 none, 1 every get, 2 every other get
  task automatic runPairs(input int n, input int lateMode, input logic u, input logic f);
    logic pa, ga;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, f, pa, ga);
      step(1'b0, 1'b1, (lateMode == 1) || (lateMode == 2 && i % 2 == 0), u, f, pa, ga);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic pa, ga;
    doReset();
    chk("R1 reset limit", slipLimit, 4);
    chk("R1 reset occupancy", occupancy, 0);

    // Vector table: R2 put gate, R3 get gate, R4 simultaneous put/get, R5 no early change
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], pa, ga);
      chk($sformatf("R2 putAck vec%0d", i), pa, VEC[i][6]);
      chk($sformatf("R3 getAck vec%0d", i), ga, VEC[i][5]);
      chk($sformatf("R4 occupancy vec%0d", i), occupancy, VEC[i][4:0]);
      chk($sformatf("R5 limit steady vec%0d", i), slipLimit, 4);
    end

    // R1 from a dirty state
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, pa, ga);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pa, ga);
    doReset();
    chk("R1 reset occupancy after use", occupancy, 0);
    chk("R1 reset limit after use", slipLimit, 4);

    // R5 + R7: all late
    runPairs(63, 1, 1'b0, 1'b0);
    chk("R5 no change before 64th get", slipLimit, 4);
    runPairs(1, 1, 1'b0, 1'b0);
    chk("R7 late window raises limit", slipLimit, 5);

    // R8 + R10: all useful, stale late tally would raise instead
    runPairs(64, 0, 1'b1, 1'b0);
    chk("R10 R8 useful window lowers limit", slipLimit, 4);

    // R6: buffer full holds the limit
    runPairs(64, 0, 1'b1, 1'b1);
    chk("R6 full buffer holds limit", slipLimit, 4);

    // R8 tie: 32 late, 64 useful -> 64 > 64 false -> fall
    runPairs(64, 2, 1'b1, 1'b0);
    chk("R8 tie lowers limit", slipLimit, 3);

    // R9 lower clamp
    for (int w = 0; w < 3; w++) runPairs(64, 0, 1'b1, 1'b0);
    chk("R9 lower clamp at 1", slipLimit, 1);

    // R9 upper clamp
    for (int w = 0; w < 15; w++) runPairs(64, 1, 1'b0, 1'b0);
    chk("R9 reach 16", slipLimit, 16);
    runPairs(64, 1, 1'b0, 1'b0);
    chk("R9 upper clamp at 16", slipLimit, 16);

    // R11: lower the limit while the queue is full
    runPairs(63, 0, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pa, ga);
    chk("R2 filled to limit", occupancy, 16);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pa, ga);
    chk("R2 put refused at limit", pa, 0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, pa, ga);
    chk("R11 limit lowered", slipLimit, 15);
    chk("R11 occupancy kept", occupancy, 15);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pa, ga);
    chk("R11 put refused at new limit", pa, 0);
    chk("R11 occupancy unchanged by refused put", occupancy, 15);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, pa, ga);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pa, ga);
    chk("R11 put accepted below new limit", pa, 1);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, pa, ga);
    chk("R11 every token drained", occupancy, 0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, pa, ga);
    chk("R3 get refused when empty", ga, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule